// File: doc/BRIEF.md
# Serial DAC Word Receiver with Load Control

This block is the receiving end of a three-wire serial link that feeds a 16-bit DAC. An active-low frame input opens a transfer. A serial data line is sampled on each falling edge of a serial clock. The bits are shifted, most significant first, into an assembly register. When the sixteenth bit has arrived, a load input decides what happens next. If it is low at that moment, the word goes straight into the DAC register. If it is high, the word waits in a holding register until the load input falls. Every change of the DAC register comes with a one-cycle update pulse.

All four serial inputs are asynchronous to the system clock. Each passes through a synchronizer, and edges are detected on the synchronized levels. The serial clock must therefore be much slower than the system clock. A frame that closes before sixteen bits have arrived is dropped and raises an error flag. The frame input can share its wire with the frame of the opposite direction, so the block only needs the frame to return high between words.

Top module: `sdac_serial_rx`

## Requirements
- R1: After reset, the DAC word is 0, the update pulse is low and the error flag is low.
- R2: While the frame is low, each falling serial clock edge samples one data bit, most significant bit first. Bit 15 of the word is the first bit sampled and bit 0 is the sixteenth.
- R3: If the load input is low when the sixteenth bit is sampled, the DAC word takes the assembled value with exactly one update pulse, SYNC_STAGES+2 clock cycles after the sixteenth falling serial clock edge.
- R4: If the load input is high when the sixteenth bit is sampled, the DAC word and the update pulse do not change. On the next falling edge of the load input, the DAC word takes the most recently completed word with exactly one update pulse, SYNC_STAGES+1 cycles after that edge.
- R5: A falling load edge when no completed word is waiting produces no update pulse and leaves the DAC word unchanged.
- R6: If the frame rises after fewer than 16 bits (including zero), the partial word is discarded: there is no update and the DAC word is unchanged, and the error flag goes high.
- R7: The error flag stays high until the next falling frame edge, which clears it.
- R8: Falling serial clock edges after the sixteenth within the same frame are ignored.
- R9: Each falling frame edge restarts bit counting at bit 15. A frame that rises after a complete word sets no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_n_i | input | 1 | Active-low frame, asynchronous |
| sclk_i | input | 1 | Serial clock, data sampled on its falling edge |
| sdi_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Load control: low selects immediate update, a falling edge releases a held word |
| dac_word_o | output | WORD_W | DAC register contents |
| dac_upd_o | output | 1 | One-cycle pulse when the DAC register is written |
| frame_err_o | output | 1 | Short frame seen, cleared by the next frame start |

## Verification
An immediate update appears SYNC_STAGES+2 cycles after the sixteenth falling serial edge: two synchronizer stages, one cycle to register the completed word, and one cycle to register the DAC write. A strobed update appears SYNC_STAGES+1 cycles after the load input falls. For one frame of each kind, the bench drives the deciding edge just after a falling system clock edge. It then counts falling clock edges and checks that the DAC word is still unchanged one cycle before the due cycle and has its new value, with the pulse high, in the due cycle. Every other result is read after at least eight idle cycles, so it has settled. Update pulses are counted continuously, which makes missing or extra pulses visible.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned SDAC_WORD_W_DEF = 16;
  localparam int unsigned SDAC_SYNC_DEF   = 2;

  // bit positions of the synchronized input vector
  typedef enum int unsigned {
    IN_FRAME = 0,
    IN_SCLK  = 1,
    IN_SDI   = 2,
    IN_LOAD  = 3
  } sdac_in_idx_e;

  localparam int unsigned SDAC_IN_N = 4;
endpackage

// File: rtl/sdac_rst_sync.sv
module sdac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_in_sync.sv
module sdac_in_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] st_q;
    logic [STAGES-1:0] st_d;

    assign st_d = {st_q[STAGES-2:0], din[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= {STAGES{RST_VAL[b]}};
      else        st_q <= st_d;
    end

    assign lvl_o[b] = st_q[STAGES-1];
  end
endmodule

// File: rtl/sdac_shift_rx.sv
module sdac_shift_rx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              frm_prev_q, sck_prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              frm_fall, frm_rise, sck_fall;
  logic              cnt_en, sh_en;

  assign frm_fall = frm_prev_q & ~frm_i;
  assign frm_rise = ~frm_prev_q & frm_i;
  assign sck_fall = sck_prev_q & ~sck_i;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    err_d  = err_q;
    cnt_en = 1'b0;
    sh_en  = 1'b0;
    if (frm_fall) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
      err_d  = 1'b0;
    end else if (frm_rise) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
      if (cnt_q != FULL) err_d = 1'b1;
    end else if (!frm_i && sck_fall && (cnt_q != FULL)) begin
      sh_d   = {sh_q[WORD_W-2:0], sdi_i};
      sh_en  = 1'b1;
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
      done_d = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_prev_q <= 1'b1;
      sck_prev_q <= 1'b1;
      cnt_q      <= '0;
      sh_q       <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      frm_prev_q <= frm_i;
      sck_prev_q <= sck_i;
      if (cnt_en) cnt_q <= cnt_d;
      if (sh_en)  sh_q  <= sh_d;
      done_q     <= done_d;
      err_q      <= err_d;
    end
  end

  assign word_o = sh_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_fall |=> !err_q);
  assert_done_needs_low_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(!frm_i));
endmodule

// File: rtl/sdac_load_ctrl.sv
module sdac_load_ctrl #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ld_i,
  output logic [WORD_W-1:0] dac_o,
  output logic              upd_o
);
  logic              ld_prev_q, ld_fall;
  logic [WORD_W-1:0] hold_q, hold_d, dac_q, dac_d;
  logic              pend_q, pend_d, upd_q, upd_d;
  logic              hold_en, dac_en;

  assign ld_fall = ld_prev_q & ~ld_i;

  always_comb begin
    hold_d  = hold_q;
    dac_d   = dac_q;
    pend_d  = pend_q;
    upd_d   = 1'b0;
    hold_en = 1'b0;
    dac_en  = 1'b0;
    if (done_i) begin
      if (!ld_i) begin
        dac_d  = word_i;
        dac_en = 1'b1;
        upd_d  = 1'b1;
        pend_d = 1'b0;
      end else begin
        hold_d  = word_i;
        hold_en = 1'b1;
        pend_d  = 1'b1;
      end
    end else if (ld_fall && pend_q) begin
      dac_d  = hold_q;
      dac_en = 1'b1;
      upd_d  = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_prev_q <= 1'b1;
      hold_q    <= '0;
      dac_q     <= '0;
      pend_q    <= 1'b0;
      upd_q     <= 1'b0;
    end else begin
      ld_prev_q <= ld_i;
      if (hold_en) hold_q <= hold_d;
      if (dac_en)  dac_q  <= dac_d;
      pend_q    <= pend_d;
      upd_q     <= upd_d;
    end
  end

  assign dac_o = dac_q;
  assign upd_o = upd_q;

  assert_upd_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> $past(done_i || ld_fall));
  assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(dac_q));
  assert_idle_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && !pend_q && !done_i) |=> !upd_q);
endmodule

// File: rtl/sdac_serial_rx.sv
module sdac_serial_rx
  import sdac_pkg::*;
#(
  parameter int unsigned WORD_W      = SDAC_WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = SDAC_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              load_n_i,
  output logic [WORD_W-1:0] dac_word_o,
  output logic              dac_upd_o,
  output logic              frame_err_o
);
  localparam logic [SDAC_IN_N-1:0] IN_RST = 4'b1011;

  logic                 rst_sync_n;
  logic [SDAC_IN_N-1:0] raw, lvl;
  logic [WORD_W-1:0]    word;
  logic                 done;

  assign raw[IN_FRAME] = frame_n_i;
  assign raw[IN_SCLK]  = sclk_i;
  assign raw[IN_SDI]   = sdi_i;
  assign raw[IN_LOAD]  = load_n_i;

  sdac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  sdac_in_sync #(.WIDTH(SDAC_IN_N), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(raw), .lvl_o(lvl));

  sdac_shift_rx #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n),
    .frm_i(lvl[IN_FRAME]), .sck_i(lvl[IN_SCLK]), .sdi_i(lvl[IN_SDI]),
    .word_o(word), .done_o(done), .err_o(frame_err_o));

  sdac_load_ctrl #(.WORD_W(WORD_W)) u_load (
    .clk(clk), .rst_n(rst_sync_n),
    .done_i(done), .word_i(word), .ld_i(lvl[IN_LOAD]),
    .dac_o(dac_word_o), .upd_o(dac_upd_o));

  assert_err_no_update_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(frame_err_o) |-> !dac_upd_o);
endmodule

// File: tb/sdac_serial_rx_tb.sv
module sdac_serial_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, sclk = 1'b1, sdi = 1'b0, load_n = 1'b0;
  logic [W-1:0] dac_word;
  logic dac_upd, frame_err;

  int n_chk = 0;
  int n_fail = 0;
  int upd_cnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_serial_rx #(.WORD_W(W), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .sclk_i(sclk), .sdi_i(sdi),
    .load_n_i(load_n), .dac_word_o(dac_word), .dac_upd_o(dac_upd),
    .frame_err_o(frame_err));

  always @(negedge clk) if (dac_upd === 1'b1) upd_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits data bits of word (MSB first), then extra bits of ones; optional checks
  task automatic send_frame(input logic [W-1:0] word, input int nbits, input int extra,
                            input bit chk_lat, input bit chk_clr);
    logic [W-1:0] prev;
    frame_n = 1'b0;
    idle(6);
    if (chk_clr) check("R7 error cleared by frame start", 32'(frame_err), 32'd0);
    for (int i = 0; i < nbits + extra; i++) begin
      sdi = (i < nbits) ? word[W-1-i] : 1'b1;
      idle(2);
      sclk = 1'b0;
      if (chk_lat && i == nbits - 1) begin
        prev = dac_word;
        idle(SYNC + 1);
        check("R3 word not early", 32'(dac_word), 32'(prev));
        idle(1);
        check("R3 word due", 32'(dac_word), 32'(word));
        check("R3 pulse due", 32'(dac_upd), 32'd1);
      end else begin
        idle(3);
      end
      sclk = 1'b1;
      idle(2);
    end
    frame_n = 1'b1;
    idle(8);
  endtask

  task automatic strobe(input bit chk_lat, input logic [W-1:0] exp);
    logic [W-1:0] prev;
    load_n = 1'b0;
    if (chk_lat) begin
      prev = dac_word;
      idle(SYNC);
      check("R4 strobe not early", 32'(dac_word), 32'(prev));
      idle(1);
      check("R4 strobe due", 32'(dac_word), 32'(exp));
      check("R4 strobe pulse", 32'(dac_upd), 32'd1);
      idle(3);
    end else begin
      idle(6);
    end
    load_n = 1'b1;
    idle(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    logic [W-1:0] last;
    logic [W-1:0] pats [6];
    pats[0] = 16'hA5C3; pats[1] = 16'hFFFF; pats[2] = 16'h0000;
    pats[3] = 16'h8001; pats[4] = 16'h7FFE; pats[5] = 16'h3C96;

    idle(5);
    rst_n = 1'b1;
    idle(6);
    check("R1 reset word", 32'(dac_word), 32'd0);
    check("R1 reset pulse count", 32'(upd_cnt), 32'd0);
    check("R1 reset error", 32'(frame_err), 32'd0);

    // immediate mode: walking ones and assorted patterns
    load_n = 1'b0;
    idle(4);
    send_frame(16'hC0DE, W, 0, 1'b1, 1'b0);
    for (int i = 0; i < W + 6; i++) begin
      logic [W-1:0] w;
      w = (i < W) ? (16'h1 << i) : pats[i - W];
      base = upd_cnt;
      send_frame(w, W, 0, 1'b0, 1'b0);
      check("R2 word bit order", 32'(dac_word), 32'(w));
      check("R3 single pulse", 32'(upd_cnt - base), 32'd1);
      check("R9 no error after full word", 32'(frame_err), 32'd0);
    end

    // short frames at every length, each followed by a clean frame
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] w;
      last = dac_word;
      base = upd_cnt;
      send_frame(16'hFFFF ^ 16'(k * 16'h1111), k, 0, 1'b0, 1'b0);
      check("R6 short frame word kept", 32'(dac_word), 32'(last));
      check("R6 short frame no pulse", 32'(upd_cnt - base), 32'd0);
      check("R6 error set", 32'(frame_err), 32'd1);
      w = 16'h1234 + 16'(k * 16'h0F0F);
      base = upd_cnt;
      send_frame(w, W, 0, 1'b0, 1'b1);
      check("R9 count restarted", 32'(dac_word), 32'(w));
      check("R9 single pulse", 32'(upd_cnt - base), 32'd1);
    end

    // extra serial clocks after the word
    for (int e = 1; e <= 4; e++) begin
      logic [W-1:0] w;
      w = 16'h0F00 >> e;
      base = upd_cnt;
      send_frame(w, W, e, 1'b0, 1'b0);
      check("R8 extra edges ignored", 32'(dac_word), 32'(w));
      check("R8 one pulse", 32'(upd_cnt - base), 32'd1);
      check("R8 no error", 32'(frame_err), 32'd0);
    end

    // strobe mode
    load_n = 1'b1;
    idle(6);
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] w;
      w = pats[i] ^ 16'h5A5A;
      last = dac_word;
      base = upd_cnt;
      send_frame(w, W, 0, 1'b0, 1'b0);
      check("R4 held word not shown", 32'(dac_word), 32'(last));
      check("R4 no pulse before strobe", 32'(upd_cnt - base), 32'd0);
      strobe(i == 0, w);
      check("R4 strobe loads word", 32'(dac_word), 32'(w));
      check("R4 strobe single pulse", 32'(upd_cnt - base), 32'd1);
      base = upd_cnt;
      strobe(1'b0, w);
      check("R5 idle strobe no pulse", 32'(upd_cnt - base), 32'd0);
      check("R5 idle strobe word kept", 32'(dac_word), 32'(w));
    end

    // two words before one strobe: newest wins
    base = upd_cnt;
    send_frame(16'h1111, W, 0, 1'b0, 1'b0);
    send_frame(16'h2222, W, 0, 1'b0, 1'b0);
    strobe(1'b0, 16'h2222);
    check("R4 newest held word", 32'(dac_word), 32'h2222);
    check("R4 one pulse for two words", 32'(upd_cnt - base), 32'd1);

    // short frame in strobe mode leaves held word intact
    send_frame(16'h4444, W, 0, 1'b0, 1'b0);
    base = upd_cnt;
    send_frame(16'h9999, 7, 0, 1'b0, 1'b0);
    check("R6 error in strobe mode", 32'(frame_err), 32'd1);
    strobe(1'b0, 16'h4444);
    check("R6 partial word not held", 32'(dac_word), 32'h4444);
    check("R4 pulse after short frame", 32'(upd_cnt - base), 32'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule